// File: doc/BRIEF.md
# Memory Controller Mode-Programming Sequencer

This block is the configuration and start-up front end of a dynamic video-memory controller. It holds a 23-bit configuration word. The low 22 bits come from the address bus and the top bit comes from a separate programming line, `prog_x`. The word can be loaded in two ways. In the standalone way, the word is taken when the mode-load strobe is released. In the access way, the host raises mode-load, selects the chip and issues an access request, and the word is taken when the request rises.

The first load after reset starts an initialization interval. The interval lasts `INIT_TICKS` refresh periods. One refresh period is (divisor+1)×(fine-tune+1) clocks, and both values are read from fixed fields of the configuration word. Refresh requests keep coming throughout the interval and after it. A status line reports refresh activity in one of two styles, chosen by the configuration word:
- In hold style it stays high for the whole interval.
- In toggle style it flips on every refresh request.

Host accesses get wait states until the block is programmed, the interval has ended and the row precharge has been met. Later loads change the word but never restart the interval.

Top module: `vmc_mode_prog`

## Requirements
- R1: After the synchronous reset `rst`, `cfg_q` is 0 and `programmed`, `initializing`, `rfsh_req` and `rfsh_stat` are all 0.
- R2: Standalone load: at the first rising edge where `mode_ld` is sampled low after having been high, `{prog_x, addr}` is stored into `cfg_q`, with `prog_x` at bit 22 and `addr` at bits 21:0. This applies only if no access load took place during that assertion. The new value is visible after that edge.
- R3: Access load: while `mode_ld` is high, the first edge where `cs` and `areq` are both high and `areq` was low at the previous edge stores `{prog_x, addr}`. The later release of `mode_ld` does not store the word again.
- R4: `ads_ok` is 0 whenever `mode_ld` is high and otherwise equals `ads`.
- R5: The first load after reset sets `programmed`, which stays set until reset. It also raises `initializing` for exactly `INIT_TICKS`×(d+1)×(f+1) clock cycles, where d = `cfg_q[2:0]` and f = `cfg_q[5:3]`.
- R6: A load while `programmed` is set updates `cfg_q` but does not raise `initializing` again.
- R7: While programmed, `rfsh_req` is a one-cycle pulse once every (d+1)×(f+1) cycles. The first pulse comes that many cycles after the first load edge.
- R8: When `cfg_q[22]` is 1 (hold style), `rfsh_stat` equals `initializing`: high through the interval and low afterwards.
- R9: When `cfg_q[22]` is 0 (toggle style), `rfsh_stat` changes value exactly in the cycles where `rfsh_req` is high.
- R10: `wait_req` is 1 when `cs` and `areq` are high with `mode_ld` low, unless the block is programmed, out of its interval, and `prech_ok` has been seen high since the interval ended (including in the current cycle).
- R11: Reset in the middle of the interval clears the word and both flags, and the next load starts a fresh interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_ld | input | 1 | Mode-load strobe, active high |
| cs | input | 1 | Chip select |
| areq | input | 1 | Access request |
| ads | input | 1 | Address strobe / latch enable from host |
| addr | input | 22 | Address bus, source of bits 21:0 of the word |
| prog_x | input | 1 | Extra programming bit, source of bit 22 |
| prech_ok | input | 1 | Row precharge satisfied, from the timing generator |
| cfg_q | output | 23 | Configuration word |
| programmed | output | 1 | A load has happened since reset |
| initializing | output | 1 | Start-up interval running |
| rfsh_req | output | 1 | One-cycle refresh request pulse |
| rfsh_stat | output | 1 | Refresh status line, hold or toggle style |
| wait_req | output | 1 | Insert wait states into the host access |
| ads_ok | output | 1 | Address strobe passed on to the access logic |

## Verification
The bench sweeps every divisor and fine-tune value from 0 to 3 in both status styles and measures the interval length and the refresh pulse spacing against the product formula. A prescaler that counted N clocks instead of N+1 per stage would show up as a short interval or a misplaced first pulse. An access load followed by a change of the bus and a release of mode-load catches a design that stores the word a second time on release. A reload after the interval catches a design that restarts start-up. With `prech_ok` held low after the interval, the wait line must stay high; a design that released waits at the end of the interval alone would drop it too early. A reset in the middle of the interval, followed by a new load, checks that start-up runs again.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
   typedef enum logic {
      STAT_TOGGLE = 1'b0,
      STAT_HOLD   = 1'b1
   } stat_style_e;

   function automatic int unsigned period_of(input int unsigned d, input int unsigned f);
      return (d + 1) * (f + 1);
   endfunction
endpackage

// File: rtl/vmp_cfg_capture.sv
module vmp_cfg_capture #(
   parameter int ADDR_W = 22
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            mode_ld,
   input  logic            cs,
   input  logic            areq,
   input  logic [ADDR_W-1:0] addr,
   input  logic            prog_x,
   output logic [ADDR_W:0] cfg_q,
   output logic            ld_pulse
);
   logic ml_q, areq_q, acc_done;
   logic acc_hit, sa_hit;

   assign acc_hit  = mode_ld & cs & areq & ~areq_q & ~acc_done;
   assign sa_hit   = ~mode_ld & ml_q & ~acc_done;
   assign ld_pulse = acc_hit | sa_hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         ml_q     <= 1'b0;
         areq_q   <= 1'b0;
         acc_done <= 1'b0;
         cfg_q    <= '0;
      end else begin
         ml_q   <= mode_ld;
         areq_q <= areq;
         if (ld_pulse) cfg_q <= {prog_x, addr};
         if (!mode_ld)     acc_done <= 1'b0;
         else if (acc_hit) acc_done <= 1'b1;
      end
   end
endmodule

// File: rtl/vmp_tick_gen.sv
module vmp_tick_gen #(
   parameter int DIV_W = 3,
   parameter int FT_W  = 3,
   localparam int FTP  = (FT_W > 0) ? FT_W : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   input  logic [FTP-1:0]   ft,
   output logic             tick
);
   logic [DIV_W-1:0] c1;
   logic             wrap1;

   assign wrap1 = (c1 >= div);

   always_ff @(posedge clk) begin
      if (rst || !run) c1 <= '0;
      else             c1 <= wrap1 ? '0 : c1 + 1'b1;
   end

   generate
      if (FT_W > 0) begin : g_two_stage
         logic [FT_W-1:0] c2;
         logic            wrap2;
         assign wrap2 = (c2 >= ft);
         always_ff @(posedge clk) begin
            if (rst || !run) c2 <= '0;
            else if (wrap1)  c2 <= wrap2 ? '0 : c2 + 1'b1;
         end
         assign tick = run & wrap1 & wrap2;
      end else begin : g_one_stage
         logic unused_ft;
         assign unused_ft = ^ft;
         assign tick = run & wrap1;
      end
   endgenerate
endmodule

// File: rtl/vmp_init_seq.sv
module vmp_init_seq #(
   parameter int INIT_TICKS = 4096,
   localparam int CNT_W     = $clog2(INIT_TICKS + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic ld_pulse,
   input  logic tick,
   input  logic prech_ok,
   output logic programmed,
   output logic initializing,
   output logic rfsh_req,
   output logic tog_q,
   output logic ready
);
   logic [CNT_W-1:0] cnt;
   logic             prech_seen;
   logic             post_init;

   assign post_init = programmed & ~initializing;
   assign ready     = prech_seen | (post_init & prech_ok);

   always_ff @(posedge clk) begin
      if (rst) begin
         programmed   <= 1'b0;
         initializing <= 1'b0;
         cnt          <= '0;
         rfsh_req     <= 1'b0;
         tog_q        <= 1'b0;
         prech_seen   <= 1'b0;
      end else begin
         if (ld_pulse && !programmed) begin
            programmed   <= 1'b1;
            initializing <= 1'b1;
            cnt          <= '0;
         end else if (initializing && tick) begin
            if (cnt == CNT_W'(INIT_TICKS - 1)) initializing <= 1'b0;
            else                               cnt <= cnt + 1'b1;
         end
         rfsh_req <= tick;
         tog_q    <= tog_q ^ tick;
         if (post_init && prech_ok) prech_seen <= 1'b1;
      end
   end
endmodule

// File: rtl/vmc_mode_prog.sv
module vmc_mode_prog #(
   parameter int ADDR_W     = 22,
   parameter int DIV_LSB    = 0,
   parameter int DIV_W      = 3,
   parameter int FT_LSB     = 3,
   parameter int FT_W       = 3,
   parameter int INIT_TICKS = 4096
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mode_ld,
   input  logic              cs,
   input  logic              areq,
   input  logic              ads,
   input  logic [ADDR_W-1:0] addr,
   input  logic              prog_x,
   input  logic              prech_ok,
   output logic [ADDR_W:0]   cfg_q,
   output logic              programmed,
   output logic              initializing,
   output logic              rfsh_req,
   output logic              rfsh_stat,
   output logic              wait_req,
   output logic              ads_ok
);
   import vmp_pkg::*;

   localparam int XB  = ADDR_W;
   localparam int FTP = (FT_W > 0) ? FT_W : 1;

   generate
      if (DIV_W < 1 || DIV_LSB + DIV_W > ADDR_W) begin : g_bad_div
         $error("divisor field outside address bits");
      end
      if (FT_W > 0 && FT_LSB + FT_W > ADDR_W) begin : g_bad_ft
         $error("fine-tune field outside address bits");
      end
      if (INIT_TICKS < 1) begin : g_bad_ticks
         $error("INIT_TICKS must be at least 1");
      end
   endgenerate

   logic             ld_pulse, tick, tog_q, ready;
   logic [DIV_W-1:0] div_f;
   logic [FTP-1:0]   ft_f;
   stat_style_e      style;

   assign div_f = cfg_q[DIV_LSB +: DIV_W];
   generate
      if (FT_W > 0) begin : g_ft
         assign ft_f = cfg_q[FT_LSB +: FT_W];
      end else begin : g_noft
         assign ft_f = '0;
      end
   endgenerate

   vmp_cfg_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk(clk), .rst(rst), .mode_ld(mode_ld), .cs(cs), .areq(areq),
      .addr(addr), .prog_x(prog_x), .cfg_q(cfg_q), .ld_pulse(ld_pulse)
   );

   vmp_tick_gen #(.DIV_W(DIV_W), .FT_W(FT_W)) u_tick (
      .clk(clk), .rst(rst), .run(programmed), .div(div_f), .ft(ft_f), .tick(tick)
   );

   vmp_init_seq #(.INIT_TICKS(INIT_TICKS)) u_seq (
      .clk(clk), .rst(rst), .ld_pulse(ld_pulse), .tick(tick), .prech_ok(prech_ok),
      .programmed(programmed), .initializing(initializing), .rfsh_req(rfsh_req),
      .tog_q(tog_q), .ready(ready)
   );

   assign style     = stat_style_e'(cfg_q[XB]);
   assign rfsh_stat = (style == STAT_HOLD) ? initializing : tog_q;
   assign wait_req  = cs & areq & ~mode_ld & ~ready;
   assign ads_ok    = ads & ~mode_ld;
endmodule

// File: rtl/vmp_checker.sv
module vmp_checker #(
   parameter int ADDR_W = 22
) (
   input logic            clk,
   input logic            rst,
   input logic            mode_ld,
   input logic            cs,
   input logic            areq,
   input logic [ADDR_W:0] cfg_q,
   input logic            programmed,
   input logic            initializing,
   input logic            rfsh_req,
   input logic            rfsh_stat,
   input logic            wait_req,
   input logic            ads_ok
);
   p_ads_gate_r4: assert property (@(posedge clk) disable iff (rst)
      mode_ld |-> !ads_ok);

   p_wait_unprog_r10: assert property (@(posedge clk) disable iff (rst)
      (cs && areq && !mode_ld && !programmed) |-> wait_req);

   p_wait_init_r10: assert property (@(posedge clk) disable iff (rst)
      (cs && areq && !mode_ld && initializing) |-> wait_req);

   p_init_needs_prog_r5: assert property (@(posedge clk) disable iff (rst)
      initializing |-> programmed);

   p_prog_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      programmed |=> programmed);

   p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
      (programmed && !initializing) |=> !initializing);

   p_toggle_r9: assert property (@(posedge clk) disable iff (rst)
      (rfsh_req && !cfg_q[ADDR_W] && $stable(cfg_q[ADDR_W])) |-> (rfsh_stat != $past(rfsh_stat)));

   p_reset_clear_r11: assert property (@(posedge clk)
      $past(rst) |-> (!programmed && !initializing && !rfsh_req));
endmodule

bind vmc_mode_prog vmp_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst(rst), .mode_ld(mode_ld), .cs(cs), .areq(areq),
   .cfg_q(cfg_q), .programmed(programmed), .initializing(initializing),
   .rfsh_req(rfsh_req), .rfsh_stat(rfsh_stat), .wait_req(wait_req), .ads_ok(ads_ok)
);

// File: tb/tb_vmc_mode_prog.sv
module tb_vmc_mode_prog;
   localparam int AW = 22;
   localparam int NT = 4;

   logic clk = 1'b0;
   logic rst, mode_ld, cs, areq, ads, prog_x, prech_ok;
   logic [AW-1:0] addr;
   logic [AW:0]   cfg_q;
   logic programmed, initializing, rfsh_req, rfsh_stat, wait_req, ads_ok;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   vmc_mode_prog #(.ADDR_W(AW), .INIT_TICKS(NT)) dut (
      .clk(clk), .rst(rst), .mode_ld(mode_ld), .cs(cs), .areq(areq), .ads(ads),
      .addr(addr), .prog_x(prog_x), .prech_ok(prech_ok), .cfg_q(cfg_q),
      .programmed(programmed), .initializing(initializing), .rfsh_req(rfsh_req),
      .rfsh_stat(rfsh_stat), .wait_req(wait_req), .ads_ok(ads_ok)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; mode_ld = 0; cs = 0; areq = 0; ads = 0; prog_x = 0; prech_ok = 0; addr = '0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // returns at the negedge of cycle 0 after the load edge
   task automatic sa_load(input logic x, input logic [AW-1:0] a);
      @(negedge clk);
      mode_ld = 1'b1; addr = a; prog_x = x;
      @(negedge clk);
      mode_ld = 1'b0;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      rst = 1'b1; mode_ld = 0; cs = 0; areq = 0; ads = 0; prog_x = 0; prech_ok = 0; addr = '0;
      do_reset();
      @(negedge clk);
      check("R1 cfg", 32'(cfg_q), 0);
      check("R1 programmed", 32'(programmed), 0);
      check("R1 initializing", 32'(initializing), 0);
      check("R1 rfsh_req", 32'(rfsh_req), 0);
      check("R1 rfsh_stat", 32'(rfsh_stat), 0);
      cs = 1; areq = 1; #1;
      check("R10 unprogrammed wait", 32'(wait_req), 1);
      cs = 0; areq = 0;

      // sweep of divisor, fine-tune and status style
      for (int st = 0; st < 2; st++) begin
         for (int d = 0; d < 4; d++) begin
            for (int f = 0; f < 4; f++) begin
               int p, icyc, pulses, first, bad, last;
               logic [AW-1:0] a;
               p = (d + 1) * (f + 1);
               a = 22'h155540 | AW'(f << 3) | AW'(d);
               do_reset();
               sa_load(st[0], a);
               check("R2 standalone word", 32'(cfg_q), 32'({st[0], a}));
               check("R5 programmed", 32'(programmed), 1);
               icyc = 0; pulses = 0; first = -1; bad = 0; last = 0;
               for (int c = 0; c <= NT * p + p; c++) begin
                  if (initializing) icyc++;
                  if (rfsh_req) begin
                     pulses++;
                     if (first < 0) first = c;
                  end
                  if (st == 1) begin
                     if (rfsh_stat !== initializing) bad++;
                  end else begin
                     if ((rfsh_stat !== last[0]) !== rfsh_req) bad++;
                  end
                  last = int'(rfsh_stat);
                  @(negedge clk);
               end
               check("R5 interval length", 32'(icyc), 32'(NT * p));
               check("R7 first refresh", 32'(first), 32'(p));
               check("R7 refresh count", 32'(pulses), 32'(NT + 1));
               if (st == 1) check("R8 hold style", 32'(bad), 0);
               else         check("R9 toggle style", 32'(bad), 0);
            end
         end
      end

      // wait states and precharge
      do_reset();
      sa_load(1'b0, 22'h000001);
      cs = 1; areq = 1; prech_ok = 0; #1;
      check("R10 wait during init", 32'(wait_req), 1);
      for (int k = 0; k < 100 && initializing; k++) @(negedge clk);
      check("R5 interval ended", 32'(initializing), 0);
      check("R10 wait until precharge", 32'(wait_req), 1);
      prech_ok = 1; #1;
      check("R10 precharge releases", 32'(wait_req), 0);
      @(negedge clk);
      prech_ok = 0; #1;
      check("R10 precharge remembered", 32'(wait_req), 0);
      cs = 0; areq = 0;

      // reload does not restart
      sa_load(1'b1, 22'h000009);
      check("R6 reload word", 32'(cfg_q), 32'({1'b1, 22'h000009}));
      check("R6 no restart", 32'(initializing), 0);
      repeat (5) @(negedge clk);
      check("R6 still idle", 32'(initializing), 0);
      check("R8 hold style after interval", 32'(rfsh_stat), 0);

      // access load
      do_reset();
      @(negedge clk);
      mode_ld = 1; ads = 1; #1;
      check("R4 strobe blocked", 32'(ads_ok), 0);
      @(negedge clk);
      cs = 1; addr = 22'h0ABC12; prog_x = 0;
      @(negedge clk);
      check("R3 no load before request", 32'(programmed), 0);
      areq = 1;
      @(negedge clk);
      check("R3 access word", 32'(cfg_q), 32'({1'b0, 22'h0ABC12}));
      check("R3 starts interval", 32'(initializing), 1);
      addr = 22'h3FFFFF; areq = 0;
      @(negedge clk);
      cs = 0; mode_ld = 0;
      @(negedge clk);
      check("R3 release does not reload", 32'(cfg_q), 32'({1'b0, 22'h0ABC12}));
      check("R4 strobe passes", 32'(ads_ok), 1);
      ads = 0;

      // reset mid-interval
      repeat (3) @(negedge clk);
      check("R11 still initializing", 32'(initializing), 1);
      rst = 1;
      @(negedge clk);
      rst = 0;
      check("R11 word cleared", 32'(cfg_q), 0);
      check("R11 programmed cleared", 32'(programmed), 0);
      check("R11 init cleared", 32'(initializing), 0);
      sa_load(1'b0, 22'h000000);
      begin
         int icyc;
         icyc = 0;
         for (int c = 0; c < NT + 3; c++) begin
            if (initializing) icyc++;
            @(negedge clk);
         end
         check("R11 fresh interval", 32'(icyc), 32'(NT));
      end

      done = 1'b1;
      summary();
   end
endmodule